// File: doc/BRIEF.md
# UART Register Bank with Mode-Switched Address Decode

This block is the host-facing register file of a 16550-style serial port that carries extended registers. A host reaches it over a plain bus with a 3-bit offset and 8-bit data. The line control byte selects one of three access modes, and the mode decides which register answers at each offset. A fixed key value in the line control byte opens a hidden bank. In that bank the enhanced feature byte takes over the offset shared by the FIFO control and interrupt identity registers.

The block holds the line control, interrupt enable, FIFO control, modem control, divisor (low and high), enhanced feature, trigger-control, trigger-level and scratch bytes. It also does the mode-dependent read and write steering. Receive data, interrupt identity, line status and modem status come in as plain input buses from the datapath, which is not part of this block. A transmit write in operational mode gives a one-cycle `tx_push` strobe with the byte. A receive read gives a one-cycle `rx_pop` strobe. Both are single-cycle strobes with no back-pressure: the datapath must take every strobe in the cycle it is raised. Reads are combinational and are valid in the same cycle as `bus_rd`. Writes take effect at the next rising clock edge.

Top module: `uart_regbank`

## Requirements
- R1: `access_mode` is 0 (operational) when line-control bit 7 is 0. It is 2 (hidden bank) when the line-control byte equals 0xBF exactly. Otherwise it is 1 (configuration).
- R2: Offset 3 reads and writes the line-control byte in every mode. Writing 0x03 (bits 1:0 = 3, eight-bit words) returns the block to operational mode.
- R3: In operational mode, offset 0 behaves as follows. A write raises `tx_push` with `tx_byte` equal to the written byte. A read returns `rx_byte` and raises `rx_pop`. In the other two modes neither strobe is raised.
- R4: In configuration mode and in the hidden bank, offsets 0 and 1 read and write the divisor low and high bytes, and `cfg_divisor` = {high, low}. In operational mode offset 1 is the interrupt-enable byte and the divisor is left alone.
- R5: Offset 2 depends on the mode. In the hidden bank it reads and writes the enhanced feature byte. In the other modes it reads `iir_val` and a write goes to `cfg_fcr`. A write in either case leaves the other register unchanged.
- R6: Interrupt-enable bits 3:0 are always writable. Bits 7:4 take a write only while enhanced-feature bit 4 is 1, and otherwise keep their old value.
- R7: Offset 4 reads and writes the full modem-control byte in every mode. Bit 7 drives `cfg_clk_div4` only while enhanced-feature bit 4 is 1.
- R8: When enhanced-feature bit 4 and modem-control bit 6 are both 1, offsets 6 and 7 read and write the trigger-control and trigger-level bytes. Otherwise offset 6 reads `msr_val` and offset 7 is the scratch byte. The two pairs are separate storage.
- R9: Offset 5 reads `lsr_val`. Writes to offset 5, and to offset 6 while it shows `msr_val`, change no register.
- R10: Register contents persist unchanged when the mode is switched.
- R11: After reset every stored byte is 0x00 and the mode is operational.
- R12: `bus_rdata` is 0x00 in any cycle where `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_rdata | output | 8 | Read data, combinational |
| rx_byte | input | 8 | Head of the receive datapath |
| iir_val | input | 8 | Interrupt identity from the prioritiser |
| lsr_val | input | 8 | Line status |
| msr_val | input | 8 | Modem status |
| tx_push | output | 1 | One-cycle transmit strobe |
| tx_byte | output | 8 | Byte carried with `tx_push` |
| rx_pop | output | 1 | One-cycle receive consume strobe |
| access_mode | output | 2 | 0 operational, 1 configuration, 2 hidden bank |
| cfg_lcr | output | 8 | Line-control byte |
| cfg_ier | output | 8 | Interrupt-enable byte |
| cfg_fcr | output | 8 | FIFO-control byte |
| cfg_mcr | output | 8 | Modem-control byte |
| cfg_efr | output | 8 | Enhanced feature byte |
| cfg_divisor | output | 16 | Baud divisor {high, low} |
| cfg_tcr | output | 8 | Trigger-control byte |
| cfg_tlr | output | 8 | Trigger-level byte |
| cfg_clk_div4 | output | 1 | Gated clock divide-by-4 select |

## Verification
A wrong mode decode shows at once. A read in the same cycle returns the wrong register, or a transmit strobe appears or goes missing. A write lands in the wrong byte, and the matching `cfg_*` port is off one cycle later. Stale storage, such as an interrupt-enable write that breaks through the lock or an enhanced-feature byte hit from the wrong bank, stays hidden only until that register's `cfg_*` output is compared. The reference model checks those outputs on every clock, so a corrupted byte is caught within one cycle of the write that caused it.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

  typedef enum logic [1:0] {
    MODE_OP    = 2'd0,
    MODE_CFG_A = 2'd1,
    MODE_CFG_B = 2'd2
  } acc_mode_e;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_IER  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_FIFO = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_LCR  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_MCR  = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_LSR  = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_MSR  = 3'd6;
  localparam logic [ADDR_W-1:0] OFS_SPR  = 3'd7;

  localparam logic [7:0] HIDDEN_KEY = 8'hBF;

  localparam int EFR_ENH_BIT  = 4;
  localparam int MCR_TRIG_BIT = 6;
  localparam int MCR_DIV4_BIT = 7;
  localparam int IER_LOCK_LO  = 4;

  // storage slots
  localparam int SLOT_LCR = 0;
  localparam int SLOT_IER = 1;
  localparam int SLOT_FCR = 2;
  localparam int SLOT_MCR = 3;
  localparam int SLOT_DLL = 4;
  localparam int SLOT_DLH = 5;
  localparam int SLOT_EFR = 6;
  localparam int SLOT_TCR = 7;
  localparam int SLOT_TLR = 8;
  localparam int SLOT_SPR = 9;
  localparam int NUM_SLOTS = 10;

endpackage

// File: rtl/uart_mode_decode.sv
module uart_mode_decode
  import uart_regbank_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] lcr,
  output acc_mode_e         mode
);
  localparam logic [DATA_W-1:0] KEY = DATA_W'(HIDDEN_KEY);

  always_comb begin
    if (!lcr[DATA_W-1])   mode = MODE_OP;
    else if (lcr == KEY)  mode = MODE_CFG_B;
    else                  mode = MODE_CFG_A;
  end
endmodule

// File: rtl/uart_reg_store.sv
module uart_reg_store
  import uart_regbank_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  acc_mode_e         mode,
  input  logic              trig_bank,
  output logic [DATA_W-1:0] q_lcr,
  output logic [DATA_W-1:0] q_ier,
  output logic [DATA_W-1:0] q_fcr,
  output logic [DATA_W-1:0] q_mcr,
  output logic [DATA_W-1:0] q_dll,
  output logic [DATA_W-1:0] q_dlh,
  output logic [DATA_W-1:0] q_efr,
  output logic [DATA_W-1:0] q_tcr,
  output logic [DATA_W-1:0] q_tlr,
  output logic [DATA_W-1:0] q_spr
);
  logic [DATA_W-1:0] slot_q [NUM_SLOTS];
  logic [DATA_W-1:0] slot_d [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slot_we;
  logic enh;

  assign enh = slot_q[SLOT_EFR][EFR_ENH_BIT];

  always_comb begin
    slot_we = '0;
    if (wr) begin
      unique case (addr)
        OFS_DATA: if (mode != MODE_OP) slot_we[SLOT_DLL] = 1'b1;
        OFS_IER:  if (mode == MODE_OP) slot_we[SLOT_IER] = 1'b1;
                  else                 slot_we[SLOT_DLH] = 1'b1;
        OFS_FIFO: if (mode == MODE_CFG_B) slot_we[SLOT_EFR] = 1'b1;
                  else                    slot_we[SLOT_FCR] = 1'b1;
        OFS_LCR:  slot_we[SLOT_LCR] = 1'b1;
        OFS_MCR:  slot_we[SLOT_MCR] = 1'b1;
        OFS_LSR:  ;
        OFS_MSR:  if (trig_bank) slot_we[SLOT_TCR] = 1'b1;
        OFS_SPR:  if (trig_bank) slot_we[SLOT_TLR] = 1'b1;
                  else           slot_we[SLOT_SPR] = 1'b1;
        default:  ;
      endcase
    end
  end

  // next value per slot; only the interrupt-enable slot masks its upper half
  always_comb begin
    for (int s = 0; s < NUM_SLOTS; s++) slot_d[s] = wdata;
    slot_d[SLOT_IER] = {enh ? wdata[DATA_W-1:IER_LOCK_LO]
                            : slot_q[SLOT_IER][DATA_W-1:IER_LOCK_LO],
                        wdata[IER_LOCK_LO-1:0]};
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          slot_q[g] <= '0;
      else if (slot_we[g]) slot_q[g] <= slot_d[g];
    end
  end

  assign q_lcr = slot_q[SLOT_LCR];
  assign q_ier = slot_q[SLOT_IER];
  assign q_fcr = slot_q[SLOT_FCR];
  assign q_mcr = slot_q[SLOT_MCR];
  assign q_dll = slot_q[SLOT_DLL];
  assign q_dlh = slot_q[SLOT_DLH];
  assign q_efr = slot_q[SLOT_EFR];
  assign q_tcr = slot_q[SLOT_TCR];
  assign q_tlr = slot_q[SLOT_TLR];
  assign q_spr = slot_q[SLOT_SPR];
endmodule

// File: rtl/uart_read_mux.sv
module uart_read_mux
  import uart_regbank_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  acc_mode_e         mode,
  input  logic              trig_bank,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic [DATA_W-1:0] iir_val,
  input  logic [DATA_W-1:0] lsr_val,
  input  logic [DATA_W-1:0] msr_val,
  input  logic [DATA_W-1:0] q_lcr,
  input  logic [DATA_W-1:0] q_ier,
  input  logic [DATA_W-1:0] q_mcr,
  input  logic [DATA_W-1:0] q_dll,
  input  logic [DATA_W-1:0] q_dlh,
  input  logic [DATA_W-1:0] q_efr,
  input  logic [DATA_W-1:0] q_tcr,
  input  logic [DATA_W-1:0] q_tlr,
  input  logic [DATA_W-1:0] q_spr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    unique case (addr)
      OFS_DATA: sel = (mode == MODE_OP)    ? rx_byte : q_dll;
      OFS_IER:  sel = (mode == MODE_OP)    ? q_ier   : q_dlh;
      OFS_FIFO: sel = (mode == MODE_CFG_B) ? q_efr   : iir_val;
      OFS_LCR:  sel = q_lcr;
      OFS_MCR:  sel = q_mcr;
      OFS_LSR:  sel = lsr_val;
      OFS_MSR:  sel = trig_bank ? q_tcr : msr_val;
      OFS_SPR:  sel = trig_bank ? q_tlr : q_spr;
      default:  sel = '0;
    endcase
    rdata = rd ? sel : '0;
  end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_wr,
  input  logic                bus_rd,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [DATA_W-1:0]   rx_byte,
  input  logic [DATA_W-1:0]   iir_val,
  input  logic [DATA_W-1:0]   lsr_val,
  input  logic [DATA_W-1:0]   msr_val,
  output logic                tx_push,
  output logic [DATA_W-1:0]   tx_byte,
  output logic                rx_pop,
  output logic [1:0]          access_mode,
  output logic [DATA_W-1:0]   cfg_lcr,
  output logic [DATA_W-1:0]   cfg_ier,
  output logic [DATA_W-1:0]   cfg_fcr,
  output logic [DATA_W-1:0]   cfg_mcr,
  output logic [DATA_W-1:0]   cfg_efr,
  output logic [2*DATA_W-1:0] cfg_divisor,
  output logic [DATA_W-1:0]   cfg_tcr,
  output logic [DATA_W-1:0]   cfg_tlr,
  output logic                cfg_clk_div4
);
  acc_mode_e         mode;
  logic              trig_bank;
  logic              data_slot;
  logic [DATA_W-1:0] q_dll, q_dlh, q_spr;

  uart_mode_decode #(.DATA_W(DATA_W)) u_mode (
    .lcr  (cfg_lcr),
    .mode (mode)
  );

  assign trig_bank = cfg_efr[EFR_ENH_BIT] & cfg_mcr[MCR_TRIG_BIT];

  uart_reg_store #(.DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .mode      (mode),
    .trig_bank (trig_bank),
    .q_lcr     (cfg_lcr),
    .q_ier     (cfg_ier),
    .q_fcr     (cfg_fcr),
    .q_mcr     (cfg_mcr),
    .q_dll     (q_dll),
    .q_dlh     (q_dlh),
    .q_efr     (cfg_efr),
    .q_tcr     (cfg_tcr),
    .q_tlr     (cfg_tlr),
    .q_spr     (q_spr)
  );

  uart_read_mux #(.DATA_W(DATA_W)) u_rmux (
    .rd        (bus_rd),
    .addr      (bus_addr),
    .mode      (mode),
    .trig_bank (trig_bank),
    .rx_byte   (rx_byte),
    .iir_val   (iir_val),
    .lsr_val   (lsr_val),
    .msr_val   (msr_val),
    .q_lcr     (cfg_lcr),
    .q_ier     (cfg_ier),
    .q_mcr     (cfg_mcr),
    .q_dll     (q_dll),
    .q_dlh     (q_dlh),
    .q_efr     (cfg_efr),
    .q_tcr     (cfg_tcr),
    .q_tlr     (cfg_tlr),
    .q_spr     (q_spr),
    .rdata     (bus_rdata)
  );

  assign data_slot    = (mode == MODE_OP) && (bus_addr == OFS_DATA);
  assign tx_push      = bus_wr && data_slot;
  assign rx_pop       = bus_rd && data_slot;
  assign tx_byte      = bus_wdata;
  assign access_mode  = mode;
  assign cfg_divisor  = {q_dlh, q_dll};
  assign cfg_clk_div4 = cfg_mcr[MCR_DIV4_BIT] & cfg_efr[EFR_ENH_BIT];
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  bus_addr,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [7:0]  bus_rdata,
  input logic        tx_push,
  input logic        rx_pop,
  input logic [1:0]  access_mode,
  input logic [7:0]  cfg_lcr,
  input logic [7:0]  cfg_ier,
  input logic [7:0]  cfg_fcr,
  input logic [7:0]  cfg_efr,
  input logic [15:0] cfg_divisor,
  input logic        cfg_clk_div4
);
  AST_HIDDEN_ONLY_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (access_mode == 2'd2) |-> (cfg_lcr == 8'hBF)); // R1
  AST_LCR_WRITE_ONLY_AT_3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 3'd3) |=> (cfg_lcr == $past(cfg_lcr))); // R2
  AST_PUSH_OPERATIONAL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> (access_mode == 2'd0 && bus_wr)); // R3
  AST_POP_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> (bus_rd && access_mode == 2'd0)); // R3
  AST_DIVISOR_HELD_IN_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (access_mode == 2'd0) |=> (cfg_divisor == $past(cfg_divisor))); // R4
  AST_EFR_HELD_OUTSIDE_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (access_mode != 2'd2) |=> (cfg_efr == $past(cfg_efr))); // R5
  AST_FCR_HELD_IN_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (access_mode == 2'd2) |=> (cfg_fcr == $past(cfg_fcr))); // R5
  AST_IER_UPPER_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_efr[4] |=> (cfg_ier[7:4] == $past(cfg_ier[7:4]))); // R6
  AST_DIV4_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clk_div4 |-> cfg_efr[4]); // R7
  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == 8'h00)); // R12
endmodule

bind uart_regbank uart_regbank_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .bus_wr       (bus_wr),
  .bus_rd       (bus_rd),
  .bus_rdata    (bus_rdata),
  .tx_push      (tx_push),
  .rx_pop       (rx_pop),
  .access_mode  (access_mode),
  .cfg_lcr      (cfg_lcr),
  .cfg_ier      (cfg_ier),
  .cfg_fcr      (cfg_fcr),
  .cfg_efr      (cfg_efr),
  .cfg_divisor  (cfg_divisor),
  .cfg_clk_div4 (cfg_clk_div4)
);

// File: tb/uart_regbank_tb.sv
module uart_regbank_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [7:0]  rx_byte = 8'hA5;
  logic [7:0]  iir_val = 8'hC1;
  logic [7:0]  lsr_val = 8'h60;
  logic [7:0]  msr_val = 8'hB0;
  logic        tx_push, rx_pop, cfg_clk_div4;
  logic [7:0]  tx_byte;
  logic [1:0]  access_mode;
  logic [7:0]  cfg_lcr, cfg_ier, cfg_fcr, cfg_mcr, cfg_efr, cfg_tcr, cfg_tlr;
  logic [15:0] cfg_divisor;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // reference model state
  logic [7:0] m_lcr, m_ier, m_fcr, m_mcr, m_dll, m_dlh, m_efr, m_tcr, m_tlr, m_spr;

  always #(CLK_P/2) clk = ~clk;

  uart_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .rx_byte(rx_byte), .iir_val(iir_val), .lsr_val(lsr_val), .msr_val(msr_val),
    .tx_push(tx_push), .tx_byte(tx_byte), .rx_pop(rx_pop),
    .access_mode(access_mode), .cfg_lcr(cfg_lcr), .cfg_ier(cfg_ier),
    .cfg_fcr(cfg_fcr), .cfg_mcr(cfg_mcr), .cfg_efr(cfg_efr),
    .cfg_divisor(cfg_divisor), .cfg_tcr(cfg_tcr), .cfg_tlr(cfg_tlr),
    .cfg_clk_div4(cfg_clk_div4)
  );

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int m_mode();
    if (!m_lcr[7]) return 0;
    if (m_lcr == 8'hBF) return 2;
    return 1;
  endfunction

  function automatic bit m_trig();
    return m_efr[4] && m_mcr[6];
  endfunction

  function automatic logic [7:0] m_read(logic [2:0] a);
    case (a)
      3'd0: return (m_mode() == 0) ? rx_byte : m_dll;
      3'd1: return (m_mode() == 0) ? m_ier : m_dlh;
      3'd2: return (m_mode() == 2) ? m_efr : iir_val;
      3'd3: return m_lcr;
      3'd4: return m_mcr;
      3'd5: return lsr_val;
      3'd6: return m_trig() ? m_tcr : msr_val;
      default: return m_trig() ? m_tlr : m_spr;
    endcase
  endfunction

  task automatic model_reset();
    m_lcr = 0; m_ier = 0; m_fcr = 0; m_mcr = 0; m_dll = 0;
    m_dlh = 0; m_efr = 0; m_tcr = 0; m_tlr = 0; m_spr = 0;
  endtask

  task automatic model_write(logic [2:0] a, logic [7:0] d);
    int md;
    bit tb;
    md = m_mode();
    tb = m_trig();
    case (a)
      3'd0: if (md != 0) m_dll = d;
      3'd1: if (md == 0) m_ier = m_efr[4] ? d : {m_ier[7:4], d[3:0]};
            else m_dlh = d;
      3'd2: if (md == 2) m_efr = d; else m_fcr = d;
      3'd3: m_lcr = d;
      3'd4: m_mcr = d;
      3'd6: if (tb) m_tcr = d;
      3'd7: if (tb) m_tlr = d; else m_spr = d;
      default: ;
    endcase
  endtask

  task automatic compare_state();
    check("R1", "access_mode", 16'(access_mode), 16'(m_mode()));
    check("R2", "lcr", 16'(cfg_lcr), 16'(m_lcr));
    check("R6", "ier", 16'(cfg_ier), 16'(m_ier));
    check("R5", "fcr", 16'(cfg_fcr), 16'(m_fcr));
    check("R5", "efr", 16'(cfg_efr), 16'(m_efr));
    check("R7", "mcr", 16'(cfg_mcr), 16'(m_mcr));
    check("R7", "clk_div4", 16'(cfg_clk_div4), 16'(m_mcr[7] & m_efr[4]));
    check("R4", "divisor", cfg_divisor, {m_dlh, m_dll});
    check("R8", "tcr", 16'(cfg_tcr), 16'(m_tcr));
    check("R8", "tlr", 16'(cfg_tlr), 16'(m_tlr));
  endtask

  // one bus cycle: drive, check combinational outputs and state, clock, update model
  task automatic cyc(bit wr, bit rd, logic [2:0] a, logic [7:0] d, string req);
    bit op0;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    #1;
    compare_state();
    op0 = (m_mode() == 0) && (a == 3'd0);
    check(req, "rdata", 16'(bus_rdata), rd ? 16'(m_read(a)) : 16'h0);
    check("R3", "tx_push", 16'(tx_push), 16'(wr && op0));
    check("R3", "rx_pop", 16'(rx_pop), 16'(rd && op0));
    if (wr && op0) check("R3", "tx_byte", 16'(tx_byte), 16'(d));
    @(posedge clk);
    if (wr) model_write(a, d);
  endtask

  task automatic wr8(logic [2:0] a, logic [7:0] d, string req);
    cyc(1'b1, 1'b0, a, d, req);
  endtask

  task automatic rd8(logic [2:0] a, string req);
    cyc(1'b0, 1'b1, a, 8'h00, req);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11: reset values
    cyc(1'b0, 1'b0, 3'd0, 8'h00, "R11");
    rd8(3'd3, "R11");
    rd8(3'd7, "R12");
    cyc(1'b0, 1'b0, 3'd5, 8'h00, "R12");

    // operational mode
    wr8(3'd0, 8'h5A, "R3");
    rd8(3'd0, "R3");
    wr8(3'd1, 8'hFF, "R6");           // upper nibble locked
    rd8(3'd1, "R6");
    wr8(3'd2, 8'hC7, "R5");
    rd8(3'd2, "R5");
    wr8(3'd7, 8'h33, "R8");
    rd8(3'd7, "R8");
    rd8(3'd5, "R9");
    wr8(3'd5, 8'hEE, "R9");
    rd8(3'd6, "R9");
    wr8(3'd6, 8'h11, "R9");
    rd8(3'd6, "R9");

    // configuration mode
    wr8(3'd3, 8'h80, "R1");
    wr8(3'd0, 8'h34, "R4");
    wr8(3'd1, 8'h12, "R4");
    rd8(3'd0, "R4");
    rd8(3'd1, "R4");
    wr8(3'd0, 8'h34, "R3");            // no push in config mode
    rd8(3'd0, "R3");
    wr8(3'd2, 8'h07, "R5");
    rd8(3'd2, "R5");
    wr8(3'd4, 8'hC3, "R7");
    rd8(3'd4, "R7");
    rd8(3'd6, "R8");                   // enhancement off: still modem status

    // hidden bank
    wr8(3'd3, 8'hBF, "R1");
    rd8(3'd0, "R10");
    rd8(3'd1, "R10");
    wr8(3'd2, 8'h10, "R5");
    rd8(3'd2, "R5");
    wr8(3'd0, 8'h56, "R4");

    // back to operational with 8-bit words
    wr8(3'd3, 8'h03, "R2");
    rd8(3'd3, "R2");
    rd8(3'd1, "R10");
    rd8(3'd6, "R8");                   // trigger-control visible now
    wr8(3'd6, 8'h9C, "R8");
    wr8(3'd7, 8'h21, "R8");
    rd8(3'd6, "R8");
    rd8(3'd7, "R8");
    wr8(3'd1, 8'hF5, "R6");
    rd8(3'd1, "R6");
    wr8(3'd4, 8'h03, "R7");
    rd8(3'd7, "R8");                   // scratch kept its value

    // near-miss key selects configuration, not hidden bank
    wr8(3'd3, 8'hBE, "R1");
    wr8(3'd2, 8'h99, "R5");
    rd8(3'd2, "R5");
    wr8(3'd3, 8'hFF, "R1");
    wr8(3'd3, 8'h3F, "R1");
    rd8(3'd0, "R3");

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [2:0] a;
      logic [7:0] d;
      int pick;
      a = 3'($urandom_range(0, 7));
      d = 8'($urandom);
      pick = $urandom_range(0, 9);
      if (a == 3'd3) begin
        if (pick < 3) d = 8'hBF;
        else if (pick < 5) d = 8'h03;
        else if (pick < 7) d = {1'b1, d[6:0]};
      end
      rx_byte = 8'($urandom);
      iir_val = 8'($urandom);
      lsr_val = 8'($urandom);
      msr_val = 8'($urandom);
      cyc(pick[0], (pick % 3) == 0, a, d, "R10");
    end

    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    #1;
    compare_state();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule